// File: doc/BRIEF.md
# SMI Data Port Feature Negotiator

This block is a one-byte I/O port that firmware and its SMI handler use to pass data to each other. The port also lets firmware find out which optional SMI behaviours the platform offers and choose some of them. Every write to the port is a negotiation request. If the request carries the negotiation flag, it asks which features are supported. If it does not, it asks for a set of features to be enabled. The port then computes the byte that any later read returns.

The lowest bit of the byte is a plain scratch bit and always reads back as it was written. The feature set that was accepted is held in a register and driven out on `feat_sel`, where other SMI logic can use it. A compile-time mask says which features the platform offers. Accesses travel over a simple single-byte I/O bus. A single port address is decoded, and read data is returned combinationally.

Top module: `smi_port_negotiator`

## Requirements
- R1: Only accesses whose address equals `PORT_ADDR` (default 0x00B3) take effect. A write to any other address changes neither the read-back byte nor `feat_sel`. A read from any other address returns 0x00.
- R2: Bit 0 of the read-back byte equals bit 0 of the most recent write, whatever kind of request that write was.
- R3: A write with bit 1 set is a query. The next read returns bit 1 = 0 and bits 7:2 = `FEAT_MASK[7:2]`. `feat_sel` does not change.
- R4: A write with bit 1 clear is rejected when any of its bits 7:2 is set in a position where `FEAT_MASK[7:2]` is zero. The next read returns bit 1 = 1, and `feat_sel` keeps its earlier value.
- R5: A write with bit 1 clear that is not rejected is accepted. `feat_sel` takes the value of bits 7:2 of that write, with bit 2 mapped to `feat_sel[0]`. The next read returns bit 1 = 0.
- R6: After any write with bit 1 clear, accepted or rejected, bits 7:2 of the read-back byte are zero.
- R7: When `FEAT_MASK` is zero, a write of 0x00 or 0x01 reads back exactly as written, and `feat_sel` becomes zero.
- R8: A synchronous active-low reset sets the read-back byte to 0x00 and `feat_sel` to zero.
- R9: Reads have no side effects. When `rd_en` is low, `rdata` is 0x00.
- R10: Bits 1:0 of `FEAT_MASK` have no effect. A query never reports those bits as features.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | I/O address of the access |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe, combinational |
| wdata | input | 8 | Byte to be written |
| rdata | output | 8 | Read-back byte when a read hits the port, else 0x00 |
| feat_sel | output | 6 | Accepted feature selection; bit i stands for port bit i+2 |

## Verification
The main instance is built with `FEAT_MASK` = 0xB7. This gives a mix of supported feature bits (7, 5, 4, 2) and unsupported ones (6, 3). It also sets both low bits, so R10 can be checked. With that mask, queries, accepted selections and selections rejected because of one stray bit can all occur. A second instance keeps the default mask of zero. It covers the compatibility case, in which plain scratch values 0x00 and 0x01 read back unchanged and every nonzero feature request is refused.

// File: rtl/smi_port_pkg.sv
// Package: shared widths, bit positions and the port byte layout.
// Assumes a one-byte port with scratch bit 0, negotiation bit 1 and
// feature bits 7:2. The SMI handler depends on these positions.
package smi_port_pkg;
    localparam int DATA_W   = 8;
    localparam int FEAT_LSB = 2;
    localparam int FEAT_W   = DATA_W - FEAT_LSB;

    typedef struct packed {
        logic [FEAT_W-1:0] feat;    // feature bits 7:2
        logic              neg;     // negotiation flag, bit 1
        logic              scratch; // transparent bit, bit 0
    } port_byte_t;
endpackage

// File: rtl/smi_port_decode.sv
// Module: address decode for the port.
// Turns the bus strobes into write-hit and read-hit qualifiers.
// Assumes one access per cycle at most. The address is compared in full.
module smi_port_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00B3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    // Compare the full address against the port address.
    always_comb begin
        match  = (addr == PORT_ADDR);
        wr_hit = wr_en && match;
        rd_hit = rd_en && match;
    end
endmodule

// File: rtl/smi_port_engine.sv
// Module: negotiation engine.
// Computes the read-back byte for each write and holds the accepted
// feature selection. Assumes that wr_hit is already address-qualified.
// Reads never reach this module, so reads cannot change its state.
module smi_port_engine
    import smi_port_pkg::*;
#(
    parameter logic [DATA_W-1:0] FEAT_MASK = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output port_byte_t        status_q,
    output logic [FEAT_W-1:0] feat_q
);
    localparam logic [FEAT_W-1:0] SUPPORTED = FEAT_MASK[DATA_W-1:FEAT_LSB];

    port_byte_t        req;
    port_byte_t        status_d;
    logic [FEAT_W-1:0] stray;
    logic              reject;

    assign req = port_byte_t'(wdata);

    // Flag each requested feature bit that the platform does not offer.
    for (genvar i = 0; i < FEAT_W; i++) begin : g_stray
        assign stray[i] = req.feat[i] & ~SUPPORTED[i];
    end

    // Build the read-back byte from the kind of request.
    always_comb begin
        reject           = !req.neg && (|stray);
        status_d.scratch = req.scratch;
        status_d.neg     = reject;
        status_d.feat    = req.neg ? SUPPORTED : '0;
    end

    // Update the read-back register on every write that hits the port.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= '0;
        else if (wr_hit) status_q <= status_d;
    end

    // Store the selection only when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                              feat_q <= '0;
        else if (wr_hit && !req.neg && !reject)  feat_q <= req.feat & SUPPORTED;
    end

    assert_scratch_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit)) |-> (status_q.scratch == $past(wdata[0])));

    assert_query_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit) && $past(wdata[1]))
        |-> (!status_q.neg && status_q.feat == SUPPORTED && feat_q == $past(feat_q)));

    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit) && !$past(wdata[1]) &&
         ($past(wdata[DATA_W-1:FEAT_LSB]) & ~SUPPORTED) != '0)
        |-> (status_q.neg && feat_q == $past(feat_q)));

    assert_accept_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit) && !$past(wdata[1]) &&
         ($past(wdata[DATA_W-1:FEAT_LSB]) & ~SUPPORTED) == '0)
        |-> (!status_q.neg && feat_q == $past(wdata[DATA_W-1:FEAT_LSB])));

    assert_select_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit) && !$past(wdata[1])) |-> (status_q.feat == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_hit)) |-> ($stable(status_q) && $stable(feat_q)));
endmodule

// File: rtl/smi_port_negotiator.sv
// Module: top of the SMI data port with feature negotiation.
// Decodes one byte-wide I/O port, runs the negotiation engine and returns
// the read-back byte combinationally. Assumes single-byte accesses and a
// synchronous active-low reset. FEAT_MASK bits 1:0 are not used.
module smi_port_negotiator
    import smi_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00B3,
    parameter logic [DATA_W-1:0] FEAT_MASK = 8'h00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [FEAT_W-1:0]    feat_sel
);
    logic       wr_hit;
    logic       rd_hit;
    port_byte_t status_q;

    smi_port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    smi_port_engine #(.FEAT_MASK(FEAT_MASK)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wdata    (wdata),
        .status_q (status_q),
        .feat_q   (feat_sel)
    );

    // Return the stored byte only while a read hits the port.
    always_comb begin
        rdata = rd_hit ? DATA_W'(status_q) : '0;
    end

    assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == PORT_ADDR) |-> (rdata == '0));

    assert_miss_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(addr) == PORT_ADDR)) |-> $stable(feat_sel));
endmodule

// File: tb/smi_port_negotiator_tb.sv
module smi_port_negotiator_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = 16'h00B3;
    logic        wr_en = 0, rd_en = 0;
    logic        m_wr_en = 0, m_rd_en = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata, m_rdata;
    logic [5:0]  feat_sel, m_feat_sel;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    smi_port_negotiator #(.FEAT_MASK(8'hB7)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .feat_sel(feat_sel));

    smi_port_negotiator u_dut_min (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(m_wr_en), .rd_en(m_rd_en),
        .wdata(wdata), .rdata(m_rdata), .feat_sel(m_feat_sel));

    // Each entry is {write byte, expected read, expected feat_sel, req number}.
    localparam logic [29:0] VEC [0:8] = '{
        {8'h02, 8'hB4, 6'h00, 8'd3},   // R3 query, R10 low mask bits hidden
        {8'h03, 8'hB5, 6'h00, 8'd2},   // R2 scratch bit kept on query
        {8'h94, 8'h00, 6'h25, 8'd5},   // R5 accept bits 7,4,2, R6
        {8'h0D, 8'h03, 6'h25, 8'd4},   // R4 bit 3 unsupported
        {8'h02, 8'hB4, 6'h25, 8'd3},   // R3 query keeps selection
        {8'h41, 8'h03, 6'h25, 8'd4},   // R4 bit 6 unsupported
        {8'hB5, 8'h01, 6'h2D, 8'd5},   // R5 all supported, R2
        {8'h00, 8'h00, 6'h00, 8'd6},   // R6 clear all
        {8'hFC, 8'h02, 6'h00, 8'd6}    // R6 reject keeps feature bits zero
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit main);
        @(negedge clk);
        addr = a; wdata = d;
        if (main) wr_en = 1; else m_wr_en = 1;
        @(negedge clk);
        wr_en = 0; m_wr_en = 0;
    endtask

    task automatic rd(input logic [15:0] a, input bit main, output logic [7:0] v);
        addr = a;
        if (main) rd_en = 1; else m_rd_en = 1;
        #1;
        v = main ? rdata : m_rdata;
        rd_en = 0; m_rd_en = 0;
        #1;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(16'h00B3, 1, v); check("R8 reset read", v, 8'h00);
        check("R8 reset feat", {2'b0, feat_sel}, 8'h00);

        for (int i = 0; i < 9; i++) begin
            wr(16'h00B3, VEC[i][29:22], 1);
            rd(16'h00B3, 1, v);
            check($sformatf("R%0d vec %0d read", VEC[i][7:0], i), v, VEC[i][21:14]);
            check($sformatf("R%0d vec %0d feat", VEC[i][7:0], i), {2'b0, feat_sel}, {2'b0, VEC[i][13:8]});
        end

        // R1: off-address writes and reads
        wr(16'h00B3, 8'h94, 1);
        wr(16'h00B2, 8'h03, 1);
        wr(16'h01B3, 8'h00, 1);
        rd(16'h00B3, 1, v); check("R1 miss write ignored", v, 8'h00);
        check("R1 miss feat kept", {2'b0, feat_sel}, 8'h25);
        rd(16'h00B2, 1, v); check("R1 miss read zero", v, 8'h00);

        // R9: repeated reads, rd_en low
        wr(16'h00B3, 8'h03, 1);
        rd(16'h00B3, 1, v); rd(16'h00B3, 1, v);
        check("R9 reread", v, 8'hB5);
        check("R9 feat untouched", {2'b0, feat_sel}, 8'h25);
        addr = 16'h00B3; #1; check("R9 rd_en low", rdata, 8'h00);

        // R7 on default-mask instance
        wr(16'h00B3, 8'h01, 0);
        rd(16'h00B3, 0, v); check("R7 write 01", v, 8'h01);
        wr(16'h00B3, 8'h04, 0);
        rd(16'h00B3, 0, v); check("R7 reject feature", v, 8'h02);
        wr(16'h00B3, 8'h00, 0);
        rd(16'h00B3, 0, v); check("R7 write 00", v, 8'h00);
        check("R7 feat clear", {2'b0, m_feat_sel}, 8'h00);
        wr(16'h00B3, 8'h02, 0);
        rd(16'h00B3, 0, v); check("R7 empty query", v, 8'h00);

        // R8: reset after a selection
        wr(16'h00B3, 8'hB5, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(16'h00B3, 1, v); check("R8 reset clears read", v, 8'h00);
        check("R8 reset clears feat", {2'b0, feat_sel}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule